// File: doc/BRIEF.md
# Bitmap Scanline Fetch Sequencer

This block plans the video memory reads that a display controller makes on each scanline when it shows a bitmap picture. It follows a horizontal position count that the controller supplies. When that count reaches a set start position, the block opens a fetch window of 660 cycles, made of 33 slots of 20 cycles each. The first slot is a dummy slot. It reads a fixed address at the top of memory and throws the data away. Its only purpose is to keep other memory clients off the bus. The other 32 slots each read one burst of picture bytes.

In every slot the row strobe stays active for all 20 cycles. Column requests go out every other cycle, starting at the third cycle of the slot. The number of requests per slot is 4 in the low-depth modes and 8 in the high-depth modes, so a short slot ends with idle cycles that are still reserved. Read data comes back a fixed number of cycles after each request and is written in order into a 256-byte line buffer. A blocked output tells the memory arbiter that no other client may be granted the bus while the window is open. The depth mode, page base and line number are captured when the window opens.

Top module: `bitmap_fetch_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after any clock edge taken with reset high, `vram_blocked`, `vram_ras`, `vram_cas_req` and `lb_we` are all low.
- R2: If `bitmap_en` is high at a clock edge where `hcount == WIN_START`, then `vram_blocked` is high for exactly 660 consecutive cycles, starting in the cycle after that edge. It is low in all other cycles.
- R3: `vram_ras` is high in exactly the same cycles as `vram_blocked`. The window consists of 33 slots of 20 cycles each.
- R4: Within a slot, with phase p running from 0 to 19, `vram_cas_req` is a single-cycle pulse at p = 2, 4, 6, and so on. There are 4 pulses per slot when `depth_sel = 0` and 8 pulses when `depth_sel = 1`. There are no pulses at any other phase.
- R5: Every column request in the first slot (the dummy slot) carries `vram_addr = 0x1FFFF`.
- R6: For the i-th data byte of the line (i counts from 0 across slots 1 to 32), `vram_addr = page_base + line_num*S + i`, taken modulo 2^17. S is 128 when `depth_sel = 0` and 256 when `depth_sel = 1`.
- R7: Each data-slot request causes `lb_we` to go high exactly `RD_LAT` cycles later. On that write, `lb_wdata` equals `vram_rdata` in that same cycle, and `lb_addr` equals i. Dummy-slot data is never written. Each line produces 128 writes (`depth_sel = 0`) or 256 writes (`depth_sel = 1`).
- R8: `depth_sel`, `page_base` and `line_num` are captured at the edge that opens the window. Changing them while the window is open has no effect on the addresses or on the number of requests.
- R9: If `bitmap_en` is low at the edge where `hcount == WIN_START`, no window opens. In that case no request, no write and no blocked cycle occurs on that line.
- R10: `vram_cas_req` is never high while `vram_blocked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bitmap_en | input | 1 | High when a bitmap mode is selected |
| depth_sel | input | 1 | 0: 4 bytes per slot, stride 128; 1: 8 bytes per slot, stride 256 |
| page_base | input | 17 | Byte address where the picture page starts |
| line_num | input | 8 | Current display line |
| hcount | input | HC_W | Horizontal cycle position |
| vram_ras | output | 1 | Row strobe, active for every slot |
| vram_cas_req | output | 1 | Column read request pulse |
| vram_addr | output | 17 | Byte address of the request |
| vram_rdata | input | 8 | Read data, valid RD_LAT cycles after its request |
| vram_blocked | output | 1 | No other memory client may be granted |
| lb_we | output | 1 | Line-buffer write enable |
| lb_addr | output | 8 | Line-buffer write index |
| lb_wdata | output | 8 | Line-buffer write data |

## Verification
The hardest case to reach from the ports is the capture rule of R8. The window lasts 660 cycles, so mode, base and line changes that arrive in the middle of a line can only be seen in a long run. The bench therefore sweeps the horizontal count over a whole window. Partway through the window it flips `depth_sel` and moves `page_base` and `line_num`, then checks that every later address and the total write count still follow the values captured at the start. A reset applied in the middle of a window shows that the lockout and the write path are cleared at once.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

    localparam int ADDR_W    = 17;
    localparam int LINE_W    = 8;
    localparam int LB_W      = 8;
    localparam int SLOT_CYC  = 20;
    localparam int DATA_SLOT = 32;
    localparam int NUM_SLOT  = DATA_SLOT + 1;
    localparam int WIN_CYC   = NUM_SLOT * SLOT_CYC;
    localparam int PH_W      = $clog2(SLOT_CYC);
    localparam int SL_W      = $clog2(NUM_SLOT);
    localparam int REQ_FIRST = 2;
    localparam logic [ADDR_W-1:0] DUMMY_ADDR = '1;

    typedef enum logic {
        DEPTH_LO = 1'b0,
        DEPTH_HI = 1'b1
    } depth_e;

    typedef struct packed {
        depth_e              depth;
        logic [ADDR_W-1:0]   base;
        logic [LINE_W-1:0]   line;
    } line_ctx_t;

    typedef struct packed {
        logic              active;
        logic [SL_W-1:0]   slot;
        logic [PH_W-1:0]   phase;
    } slot_pos_t;

    function automatic logic [3:0] slot_bytes(depth_e d);
        return (d == DEPTH_HI) ? 4'd8 : 4'd4;
    endfunction

    function automatic int unsigned slot_shift(depth_e d);
        return (d == DEPTH_HI) ? 3 : 2;
    endfunction

    function automatic int unsigned stride_shift(depth_e d);
        return (d == DEPTH_HI) ? 8 : 7;
    endfunction

endpackage

// File: rtl/bmf_slot_timer.sv
module bmf_slot_timer
    import bmf_pkg::*;
#(
    parameter int HC_W      = 11,
    parameter int WIN_START = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bitmap_en,
    input  logic [HC_W-1:0] hcount,
    output logic            open_now,
    output slot_pos_t       pos
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYC - 1);
    localparam logic [SL_W-1:0] SL_LAST = SL_W'(NUM_SLOT - 1);

    assign open_now = !pos.active && bitmap_en && (hcount == HC_W'(WIN_START));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (!pos.active) begin
            if (open_now) begin
                pos.active <= 1'b1;
                pos.slot   <= '0;
                pos.phase  <= '0;
            end
        end else if (pos.phase == PH_LAST) begin
            pos.phase <= '0;
            if (pos.slot == SL_LAST) begin
                pos.active <= 1'b0;
            end else begin
                pos.slot <= pos.slot + 1'b1;
            end
        end else begin
            pos.phase <= pos.phase + 1'b1;
        end
    end

endmodule

// File: rtl/bmf_addr_gen.sv
module bmf_addr_gen
    import bmf_pkg::*;
(
    input  slot_pos_t         pos,
    input  line_ctx_t         ctx,
    output logic              req,
    output logic              req_data,
    output logic [ADDR_W-1:0] addr
);

    logic [PH_W-1:0]   off;
    logic [3:0]        k;
    logic [SL_W-1:0]   slot_m1;
    logic [ADDR_W-1:0] row_off;
    logic [ADDR_W-1:0] byte_idx;

    always_comb begin
        off      = pos.phase - PH_W'(REQ_FIRST);
        k        = 4'(off >> 1);
        req      = pos.active && (pos.phase >= PH_W'(REQ_FIRST)) && !off[0]
                   && (k < slot_bytes(ctx.depth));
        req_data = req && (pos.slot != '0);
        slot_m1  = pos.slot - 1'b1;
        row_off  = ADDR_W'(ctx.line) << stride_shift(ctx.depth);
        byte_idx = (ADDR_W'(slot_m1) << slot_shift(ctx.depth)) + ADDR_W'(k);
        if (pos.slot == '0) begin
            addr = DUMMY_ADDR;
        end else begin
            addr = ctx.base + row_off + byte_idx;
        end
    end

endmodule

// File: rtl/bmf_return_pipe.sv
module bmf_return_pipe
    import bmf_pkg::*;
#(
    parameter int RD_LAT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            req_data,
    output logic            we,
    output logic [LB_W-1:0] waddr
);

    logic [RD_LAT-1:0] pipe;

    generate
        if (RD_LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= req_data;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[RD_LAT-2:0], req_data};
            end
        end
    endgenerate

    assign we = pipe[RD_LAT-1];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            waddr <= '0;
        end else if (we) begin
            waddr <= waddr + 1'b1;
        end
    end

endmodule

// File: rtl/bitmap_fetch_seq.sv
module bitmap_fetch_seq
    import bmf_pkg::*;
#(
    parameter int HC_W      = 11,
    parameter int WIN_START = 32,
    parameter int RD_LAT    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bitmap_en,
    input  logic              depth_sel,
    input  logic [ADDR_W-1:0] page_base,
    input  logic [LINE_W-1:0] line_num,
    input  logic [HC_W-1:0]   hcount,
    output logic              vram_ras,
    output logic              vram_cas_req,
    output logic [ADDR_W-1:0] vram_addr,
    input  logic [7:0]        vram_rdata,
    output logic              vram_blocked,
    output logic              lb_we,
    output logic [LB_W-1:0]   lb_addr,
    output logic [7:0]        lb_wdata
);

    slot_pos_t pos;
    line_ctx_t ctx_q;
    logic      open_now;
    logic      req_data;

    bmf_slot_timer #(.HC_W(HC_W), .WIN_START(WIN_START)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .bitmap_en (bitmap_en),
        .hcount    (hcount),
        .open_now  (open_now),
        .pos       (pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (open_now) begin
            ctx_q.depth <= depth_e'(depth_sel);
            ctx_q.base  <= page_base;
            ctx_q.line  <= line_num;
        end
    end

    bmf_addr_gen u_addr (
        .pos      (pos),
        .ctx      (ctx_q),
        .req      (vram_cas_req),
        .req_data (req_data),
        .addr     (vram_addr)
    );

    bmf_return_pipe #(.RD_LAT(RD_LAT)) u_ret (
        .clk      (clk),
        .rst      (rst),
        .clear    (open_now),
        .req_data (req_data),
        .we       (lb_we),
        .waddr    (lb_addr)
    );

    assign vram_ras     = pos.active;
    assign vram_blocked = pos.active;
    assign lb_wdata     = vram_rdata;

endmodule

// File: rtl/bitmap_fetch_seq_chk.sv
module bitmap_fetch_seq_chk
    import bmf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              blocked,
    input logic              ras,
    input logic              cas_req,
    input logic [ADDR_W-1:0] addr,
    input logic              lb_we,
    input logic [LB_W-1:0]   lb_addr,
    input depth_e            depth_q
);

    logic [9:0]      run_len;
    logic [3:0]      req_cnt;
    logic [LB_W:0]   wr_cnt;
    logic            blocked_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= '0;
            req_cnt   <= '0;
            wr_cnt    <= '0;
            blocked_d <= 1'b0;
        end else begin
            blocked_d <= blocked;
            run_len   <= blocked ? run_len + 1'b1 : '0;
            if (!blocked)                  req_cnt <= '0;
            else if (cas_req && req_cnt != 4'hF) req_cnt <= req_cnt + 1'b1;
            if (blocked && !blocked_d)     wr_cnt <= '0;
            else if (lb_we)                wr_cnt <= wr_cnt + 1'b1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!blocked && !ras && !cas_req && !lb_we));

    // R2
    a_r2_window_len: assert property (@(posedge clk) disable iff (rst)
        $fell(blocked) |-> (run_len == 10'(WIN_CYC)));

    // R10
    a_r10_req_in_window: assert property (@(posedge clk) disable iff (rst)
        cas_req |-> (blocked && ras));

    // R4
    a_r4_req_single: assert property (@(posedge clk) disable iff (rst)
        cas_req |=> !cas_req);

    // R5
    a_r5_dummy_addr: assert property (@(posedge clk) disable iff (rst)
        (cas_req && (req_cnt < slot_bytes(depth_q))) |-> (addr == DUMMY_ADDR));

    // R7
    a_r7_lb_order: assert property (@(posedge clk) disable iff (rst)
        lb_we |-> (lb_addr == wr_cnt[LB_W-1:0]));

endmodule

bind bitmap_fetch_seq bitmap_fetch_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .blocked (vram_blocked),
    .ras     (vram_ras),
    .cas_req (vram_cas_req),
    .addr    (vram_addr),
    .lb_we   (lb_we),
    .lb_addr (lb_addr),
    .depth_q (ctx_q.depth)
);

// File: tb/sim_bitmap_fetch_seq.sv
module sim_bitmap_fetch_seq;

    localparam int HC_W      = 11;
    localparam int WIN_START = 32;
    localparam int RD_LAT    = 3;
    localparam int WIN_CYC   = 660;
    localparam int RUN_LEN   = WIN_START + WIN_CYC + RD_LAT + 12;
    localparam logic [16:0] DUMMY = 17'h1FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bitmap_en = 1'b0;
    logic        depth_sel = 1'b0;
    logic [16:0] page_base = '0;
    logic [7:0]  line_num = '0;
    logic [HC_W-1:0] hcount = '0;
    logic        vram_ras, vram_cas_req, vram_blocked, lb_we;
    logic [16:0] vram_addr;
    logic [7:0]  vram_rdata = '0;
    logic [7:0]  lb_addr, lb_wdata;

    int checks = 0;
    int fails  = 0;

    logic        hist_req [0:1023];
    logic [16:0] hist_addr[0:1023];

    always #5 clk = ~clk;

    bitmap_fetch_seq #(.HC_W(HC_W), .WIN_START(WIN_START), .RD_LAT(RD_LAT)) u0 (
        .clk(clk), .rst(rst), .bitmap_en(bitmap_en), .depth_sel(depth_sel),
        .page_base(page_base), .line_num(line_num), .hcount(hcount),
        .vram_ras(vram_ras), .vram_cas_req(vram_cas_req), .vram_addr(vram_addr),
        .vram_rdata(vram_rdata), .vram_blocked(vram_blocked),
        .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata)
    );

    function automatic logic [7:0] mem_hash(logic [16:0] a);
        return a[7:0] ^ {a[15:9], a[16]} ^ 8'h5A;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        hcount = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!vram_blocked && !vram_ras && !vram_cas_req && !lb_we, "R1 reset state",
              {vram_blocked, vram_ras, vram_cas_req, lb_we}, 0);
        rst = 1'b0;
    endtask

    // One scanline sweep; optional perturbation of inputs mid-window (R8).
    task automatic run_line(bit en, bit dsel, logic [16:0] base, logic [7:0] line,
                            bit perturb, string tag);
        int n, stride, e_blk, e_ras, e_req, e_addr, e_dummy, e_wr, wcnt, blk_cyc, reqs;
        logic [16:0] ea;
        n = dsel ? 8 : 4;
        stride = dsel ? 256 : 128;
        e_blk = 0; e_ras = 0; e_req = 0; e_addr = 0; e_dummy = 0; e_wr = 0;
        wcnt = 0; blk_cyc = 0; reqs = 0;
        bitmap_en = en; depth_sel = dsel; page_base = base; line_num = line;
        for (int h = 0; h < RUN_LEN; h++) begin
            int c, slot, ph;
            bit xb, xr;
            @(negedge clk);
            if (h >= RD_LAT && hist_req[h-RD_LAT]) vram_rdata = mem_hash(hist_addr[h-RD_LAT]);
            else vram_rdata = 8'h00;
            #1;
            c = h - 1 - WIN_START;
            xb = en && c >= 0 && c < WIN_CYC;
            slot = (c >= 0) ? c / 20 : 0;
            ph = (c >= 0) ? c % 20 : 0;
            xr = xb && ph >= 2 && (ph % 2 == 0) && ((ph - 2) / 2 < n);
            hist_req[h] = vram_cas_req;
            hist_addr[h] = vram_addr;
            if (vram_blocked !== xb) e_blk++;
            if (vram_ras !== xb) e_ras++;
            if (vram_blocked) blk_cyc++;
            if (vram_cas_req !== xr) e_req++;
            if (vram_cas_req) reqs++;
            if (xr && slot == 0 && vram_addr !== DUMMY) e_dummy++;
            if (xr && slot > 0) begin
                ea = base + 17'(line * stride) + 17'((slot - 1) * n + (ph - 2) / 2);
                if (vram_addr !== ea) e_addr++;
            end
            if (lb_we) begin
                ea = base + 17'(line * stride) + 17'(wcnt);
                if (lb_addr !== 8'(wcnt) || lb_wdata !== mem_hash(ea)) e_wr++;
                wcnt++;
            end
            hcount = HC_W'(h);
            if (perturb && h == WIN_START + 50) begin
                depth_sel = !dsel; page_base = base ^ 17'h0A5A5; line_num = line + 8'd17;
            end
        end
        check(e_blk == 0, {"R2 blocked window ", tag}, e_blk, 0);
        check(blk_cyc == (en ? WIN_CYC : 0), {"R2 blocked count ", tag}, blk_cyc, en ? WIN_CYC : 0);
        check(e_ras == 0, {"R3 ras follows window ", tag}, e_ras, 0);
        check(e_req == 0, {"R4 request phases ", tag}, e_req, 0);
        check(reqs == (en ? 33 * n : 0), {"R4 R10 request count ", tag}, reqs, en ? 33 * n : 0);
        check(e_dummy == 0, {"R5 dummy address ", tag}, e_dummy, 0);
        check(e_addr == 0, {"R6 R8 data address ", tag}, e_addr, 0);
        check(e_wr == 0, {"R7 line buffer data ", tag}, e_wr, 0);
        check(wcnt == (en ? 32 * n : 0), {"R7 R9 write count ", tag}, wcnt, en ? 32 * n : 0);
        bitmap_en = 1'b0;
    endtask

    task automatic reset_mid_window();
        bitmap_en = 1'b1; depth_sel = 1'b1;
        for (int h = 0; h < WIN_START + 100; h++) begin
            @(negedge clk);
            hcount = HC_W'(h);
        end
        @(negedge clk); #1;
        check(vram_blocked, "R2 window open before reset", vram_blocked, 1);
        rst = 1'b1;
        @(negedge clk); #1;
        check(!vram_blocked && !vram_cas_req && !lb_we && !vram_ras, "R1 reset mid window",
              {vram_blocked, vram_ras, vram_cas_req, lb_we}, 0);
        @(negedge clk);
        rst = 1'b0;
        bitmap_en = 1'b0;
        hcount = '0;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            hist_req[i] = 1'b0;
            hist_addr[i] = '0;
        end
        do_reset();
        run_line(1'b1, 1'b0, 17'h04000, 8'd5,   1'b0, "lo");
        run_line(1'b1, 1'b1, 17'h10000, 8'd200, 1'b0, "hi");
        run_line(1'b1, 1'b1, 17'h1F000, 8'd3,   1'b0, "hi wrap");
        run_line(1'b0, 1'b1, 17'h00000, 8'd9,   1'b0, "disabled");
        run_line(1'b1, 1'b0, 17'h00100, 8'd255, 1'b1, "lo perturbed");
        run_line(1'b1, 1'b1, 17'h02000, 8'd40,  1'b1, "hi perturbed");
        reset_mid_window();
        run_line(1'b1, 1'b0, 17'h1FF80, 8'd1,   1'b0, "after reset");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule